// File: doc/BRIEF.md
# Result FIFO with Temperature Slot

This block sits between a converter's result path and a byte-serial readout shifter. Voltage results go into a circular queue. When the queue is full, a new voltage result takes the place of the oldest one. A temperature result goes into a separate single-entry slot. A pending temperature result is always read out before any voltage result, and a newer temperature result replaces an older one that has not been read yet.

The read side hands out one byte for each pop strobe. Every result is sent as a 16-bit word, high byte first, with the result zero-extended from the top. The temperature value is a two's-complement number with 1/8 degree per LSB, and it is sent as raw bits without sign extension. A word is latched when its high byte is popped. Its storage is released only when its low byte is popped, so the two bytes of a word always belong together. A flush input clears the whole block in one cycle.

Top module: `res_fifo_tslot`

## Requirements
- R1: After reset or a flush, `empty_o`=1, `count_o`=0, `temp_pend_o`=0 and `rd_byte_o`=0. A flush in the same cycle as a write discards that write.
- R2: Voltage results leave in the order they were written. Each result takes two pops. The first byte is `{4'b0000, data[11:8]}` and the second is `data[7:0]`.
- R3: The queue holds up to DEPTH (16) voltage results. `count_o` gives the number stored, and `full_o` is 1 exactly when that number is DEPTH.
- R4: A voltage write to a full queue discards the oldest result and keeps the new one. `count_o` stays at DEPTH.
- R5: While a temperature result is pending and no word is half read, the next two bytes are the temperature word, ahead of any voltage results.
- R6: A temperature write replaces any unread temperature result, so only the newest one is read. `temp_pend_o` is 1 after a temperature write.
- R7: While nothing is stored, `rd_byte_o` is 0 and a pop has no effect. A result written afterwards reads back intact.
- R8: An entry is released only by its second byte pop. `count_o` does not change on the first pop. If the entry is overwritten between its two pops, the low byte still comes from the word whose high byte was read, and the entry is not released a second time.
- R9: When the queue is full and a voltage write arrives in the same cycle as the low-byte pop of the head, `count_o` stays DEPTH, nothing is dropped and nothing is duplicated.
- R10: The high byte of a negative temperature value has its upper four bits zero (no sign extension).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empties queue, temperature slot and byte phase in one cycle |
| wr_en_i | input | 1 | Result write strobe |
| wr_is_temp_i | input | 1 | 1: write goes to the temperature slot, 0: to the voltage queue |
| wr_data_i | input | RES_W (12) | Result value |
| pop_i | input | 1 | Byte pop strobe from the serial shifter |
| rd_byte_o | output | BYTE_W (8) | Byte presented for readout |
| empty_o | output | 1 | No byte available |
| full_o | output | 1 | Voltage queue holds DEPTH results |
| count_o | output | $clog2(DEPTH+1) | Number of voltage results stored |
| temp_pend_o | output | 1 | Temperature result waiting to be read |

## Verification
Every fill level from one to sixteen is written and drained, with arithmetic value patterns that differ per level. This separates ordering and byte-split errors from capacity errors. Overfilling by one to three entries shows whether the oldest or the newest result is lost. Temperature words are mixed into voltage traffic, including a negative code, to check draining priority, replacement and the absence of sign extension. Two mid-word cases are kept apart: a plain overwrite between the byte pops, and a write that coincides with the completing pop. A bad release rule shows up as a wrong count in one case or a lost entry in the other.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

    // Origin of the word currently being shifted out
    typedef enum logic {
        SRC_VOLT = 1'b0,
        SRC_TEMP = 1'b1
    } rd_src_e;

    // Byte sequencer state
    typedef struct packed {
        logic    lo_phase;  // 1: low byte of a latched word is next
        rd_src_e src;       // where the latched word came from
        logic    owed;      // low-byte pop must still release storage
    } rd_state_t;

    localparam rd_state_t RD_IDLE = '{lo_phase: 1'b0, src: SRC_VOLT, owed: 1'b0};

endpackage

// File: rtl/rfq_ring.sv
module rfq_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 12,
    parameter int PW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          drop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          ovw
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          inc;

    assign full = (cnt == CW'(DEPTH));
    assign ovw  = push & full & ~drop;
    assign inc  = push & ~ovw;
    assign head = mem[rptr];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wptr] <= pdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (drop || ovw) begin
                rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            cnt <= cnt + CW'(inc) - CW'(drop);
        end
    end

endmodule

// File: rtl/rfq_tslot.sv
module rfq_tslot #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         consume,
    output logic         valid,
    output logic [W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (wr) begin
                valid <= 1'b1;
                data  <= wdata;
            end else if (consume) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rfq_seq.sv
module rfq_seq
    import rfq_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              pop,
    input  logic              t_valid,
    input  logic [RES_W-1:0]  t_data,
    input  logic              t_wr,
    input  logic              q_nz,
    input  logic [RES_W-1:0]  q_head,
    input  logic              q_ovw,
    output logic [BYTE_W-1:0] byte_o,
    output logic              q_drop,
    output logic              t_consume,
    output logic              lo_phase,
    output logic              avail
);

    localparam int WORD_W = 2 * BYTE_W;

    rd_state_t         st, st_n;
    logic [BYTE_W-1:0] lo_hold;
    logic [RES_W-1:0]  pick;
    logic [WORD_W-1:0] word;
    logic              hi_pop, lo_pop, cur_tmp, lost_now, any_src;

    assign any_src  = t_valid | q_nz;
    assign pick     = t_valid ? t_data : q_head;
    assign word     = WORD_W'(pick);
    assign cur_tmp  = (st.src == SRC_TEMP);
    assign lost_now = cur_tmp ? t_wr : q_ovw;

    assign hi_pop    = pop & ~st.lo_phase & any_src;
    assign lo_pop    = pop & st.lo_phase;
    assign q_drop    = lo_pop & st.owed & ~cur_tmp;
    assign t_consume = lo_pop & st.owed & cur_tmp;

    assign lo_phase = st.lo_phase;
    assign avail    = st.lo_phase | any_src;
    assign byte_o   = st.lo_phase ? lo_hold
                    : (any_src ? word[WORD_W-1:BYTE_W] : '0);

    always_comb begin
        st_n = st;
        if (hi_pop) begin
            st_n.lo_phase = 1'b1;
            st_n.src      = t_valid ? SRC_TEMP : SRC_VOLT;
            st_n.owed     = ~(t_valid ? t_wr : q_ovw);
        end else if (lo_pop) begin
            st_n.lo_phase = 1'b0;
            st_n.owed     = 1'b0;
        end else if (st.lo_phase && lost_now) begin
            st_n.owed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st      <= RD_IDLE;
            lo_hold <= '0;
        end else begin
            st <= st_n;
            if (hi_pop) begin
                lo_hold <= word[BYTE_W-1:0];
            end
        end
    end

endmodule

// File: rtl/res_fifo_tslot.sv
module res_fifo_tslot
    import rfq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic              wr_en_i,
    input  logic              wr_is_temp_i,
    input  logic [RES_W-1:0]  wr_data_i,
    input  logic              pop_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [CW-1:0]     count_o,
    output logic              temp_pend_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             v_push, t_wr, q_drop, q_ovw, t_consume, t_valid;
    logic             lo_phase, avail;
    logic [RES_W-1:0] q_head, t_data;

    assign v_push = wr_en_i & ~wr_is_temp_i;
    assign t_wr   = wr_en_i & wr_is_temp_i;

    rfq_ring #(.DEPTH(DEPTH), .W(RES_W), .PW(PW), .CW(CW)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_i),
        .push  (v_push),
        .pdata (wr_data_i),
        .drop  (q_drop),
        .head  (q_head),
        .cnt   (count_o),
        .full  (full_o),
        .ovw   (q_ovw)
    );

    rfq_tslot #(.W(RES_W)) u_tslot (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush_i),
        .wr      (t_wr),
        .wdata   (wr_data_i),
        .consume (t_consume),
        .valid   (t_valid),
        .data    (t_data)
    );

    rfq_seq #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_i),
        .pop       (pop_i),
        .t_valid   (t_valid),
        .t_data    (t_data),
        .t_wr      (t_wr),
        .q_nz      (count_o != '0),
        .q_head    (q_head),
        .q_ovw     (q_ovw),
        .byte_o    (rd_byte_o),
        .q_drop    (q_drop),
        .t_consume (t_consume),
        .lo_phase  (lo_phase),
        .avail     (avail)
    );

    assign empty_o     = ~avail;
    assign temp_pend_o = t_valid;

endmodule

// File: rtl/rfq_chk.sv
module rfq_chk #(
    parameter int DEPTH  = 16,
    parameter int RES_W  = 12,
    parameter int BYTE_W = 8,
    parameter int CW     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_i,
    input logic              wr_en_i,
    input logic              wr_is_temp_i,
    input logic              pop_i,
    input logic [BYTE_W-1:0] rd_byte_o,
    input logic              empty_o,
    input logic              full_o,
    input logic [CW-1:0]     count_o,
    input logic              temp_pend_o,
    input logic              lo_phase,
    input logic              q_drop
);

    localparam int PAD = 2 * BYTE_W - RES_W;

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_o <= CW'(DEPTH));

    a_r7_empty_zero: assert property (@(posedge clk) disable iff (rst)
        empty_o |-> rd_byte_o == '0);

    a_r2_high_pad: assert property (@(posedge clk) disable iff (rst)
        !lo_phase |-> (rd_byte_o >> (BYTE_W - PAD)) == '0);

    a_r1_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (empty_o && count_o == '0 && !temp_pend_o));

    a_r4_stays_full: assert property (@(posedge clk) disable iff (rst)
        (full_o && wr_en_i && !wr_is_temp_i && !flush_i) |=> full_o);

    a_r6_temp_pending: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_is_temp_i && !flush_i) |=> temp_pend_o);

    a_r8_first_pop_keeps: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !lo_phase && !flush_i && !wr_en_i) |=> count_o == $past(count_o));

    a_r9_full_swap: assert property (@(posedge clk) disable iff (rst)
        (full_o && wr_en_i && !wr_is_temp_i && q_drop && !flush_i)
        |=> (full_o && count_o == $past(count_o)));

endmodule

bind res_fifo_tslot rfq_chk #(
    .DEPTH(DEPTH), .RES_W(RES_W), .BYTE_W(BYTE_W), .CW(CW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .wr_en_i      (wr_en_i),
    .wr_is_temp_i (wr_is_temp_i),
    .pop_i        (pop_i),
    .rd_byte_o    (rd_byte_o),
    .empty_o      (empty_o),
    .full_o       (full_o),
    .count_o      (count_o),
    .temp_pend_o  (temp_pend_o),
    .lo_phase     (lo_phase),
    .q_drop       (q_drop)
);

// File: tb/sim_res_fifo_tslot.sv
`timescale 1ns/1ps
module sim_res_fifo_tslot;

    logic        clk = 1'b0;
    logic        rst, flush, wr_en, wr_tmp, pop;
    logic [11:0] wr_data;
    logic [7:0]  rd_byte;
    logic        empty, full, tpend;
    logic [4:0]  count;
    int          vectors = 0;
    int          fails   = 0;
    bit          done    = 0;

    always #10 clk = ~clk;

    res_fifo_tslot u0 (
        .clk(clk), .rst(rst), .flush_i(flush), .wr_en_i(wr_en),
        .wr_is_temp_i(wr_tmp), .wr_data_i(wr_data), .pop_i(pop),
        .rd_byte_o(rd_byte), .empty_o(empty), .full_o(full),
        .count_o(count), .temp_pend_o(tpend)
    );

    function automatic logic [11:0] pat(int n, int i);
        return 12'((i * 397 + n * 61 + 5) % 4096);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [11:0] v, logic t);
        wr_en = 1'b1; wr_tmp = t; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_tmp = 1'b0;
    endtask

    task automatic pop1(output logic [7:0] b);
        b = rd_byte; pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic read_word(string tag, logic [11:0] exp);
        logic [7:0] h, l;
        pop1(h);
        pop1(l);
        chk(tag, {h, l}, {4'h0, exp});
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  h, l;
        logic [11:0] x;
        rst = 1'b1; flush = 0; wr_en = 0; wr_tmp = 0; pop = 0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 empty", empty, 1);
        chk("R1 count", count, 0);
        chk("R1 temp", tpend, 0);
        chk("R1 byte", rd_byte, 0);

        // R2/R3 every fill level
        for (int n = 1; n <= 16; n++) begin
            for (int i = 0; i < n; i++) push(pat(n, i), 1'b0);
            chk("R3 count", count, n);
            chk("R3 full", full, (n == 16));
            for (int i = 0; i < n; i++) read_word("R2 order", pat(n, i));
            chk("R7 drained", empty, 1);
        end

        // R4 overfill by k
        for (int k = 1; k <= 3; k++) begin
            for (int i = 0; i < 16 + k; i++) push(pat(30 + k, i), 1'b0);
            chk("R4 count", count, 16);
            for (int i = 0; i < 16; i++) read_word("R4 oldest dropped", pat(30 + k, i + k));
        end

        // R5/R10 temperature priority, negative code
        for (int i = 0; i < 3; i++) push(pat(40, i), 1'b0);
        push(12'h9A5, 1'b1);
        chk("R6 pending", tpend, 1);
        pop1(h);
        chk("R10 no sign ext", h, 8'h09);
        pop1(l);
        chk("R5 temp low", l, 8'hA5);
        chk("R5 temp gone", tpend, 0);
        for (int i = 0; i < 3; i++) read_word("R5 volts after", pat(40, i));

        // R6 replacement
        push(12'h123, 1'b1);
        push(12'hF38, 1'b1);
        read_word("R6 newest", 12'hF38);
        chk("R6 single", empty, 1);

        // R7 pop on empty ignored
        pop1(h);
        chk("R7 byte zero", h, 0);
        chk("R7 count", count, 0);
        push(12'hABC, 1'b0);
        read_word("R7 intact", 12'hABC);

        // R8 release on second pop
        push(12'h111, 1'b0);
        push(12'h222, 1'b0);
        pop1(h);
        chk("R8 first pop", count, 2);
        pop1(l);
        chk("R8 second pop", count, 1);
        read_word("R8 next", 12'h222);

        // R8 overwrite between pops
        for (int i = 0; i < 16; i++) push(pat(50, i), 1'b0);
        x = 12'h5E7;
        pop1(h);
        push(x, 1'b0);
        chk("R8 ovw count", count, 16);
        pop1(l);
        chk("R8 untorn", {h, l}, {4'h0, pat(50, 0)});
        chk("R8 no double", count, 16);
        for (int i = 1; i < 16; i++) read_word("R8 rest", pat(50, i));
        read_word("R8 newest", x);

        // R9 write with completing pop
        for (int i = 0; i < 16; i++) push(pat(60, i), 1'b0);
        x = 12'h0D4;
        pop1(h);
        l = rd_byte; pop = 1'b1; wr_en = 1'b1; wr_data = x;
        @(negedge clk);
        pop = 1'b0; wr_en = 1'b0;
        chk("R9 word", {h, l}, {4'h0, pat(60, 0)});
        chk("R9 count", count, 16);
        for (int i = 1; i < 16; i++) read_word("R9 rest", pat(60, i));
        read_word("R9 newest", x);

        // R1 flush with simultaneous write, and mid-word
        for (int i = 0; i < 3; i++) push(pat(70, i), 1'b0);
        push(12'h777, 1'b1);
        flush = 1'b1; wr_en = 1'b1; wr_data = 12'h444;
        @(negedge clk);
        flush = 1'b0; wr_en = 1'b0;
        chk("R1 flush empty", empty, 1);
        chk("R1 flush count", count, 0);
        chk("R1 flush temp", tpend, 0);
        push(12'h6A1, 1'b1);
        pop1(h);
        do_flush();
        chk("R1 flush byte", rd_byte, 0);
        push(12'h3C2, 1'b0);
        read_word("R1 after flush", 12'h3C2);

        done = 1;
        summary();
        $finish;
    end

endmodule